// File: doc/BRIEF.md
# Frequency-Loop Lock Detector with Edge Window

This block decides when a frequency-locked loop has settled. It starts once the loop's successive-approximation coarse search reports that it has finished. After that it watches the loop's increment and decrement correction signals on a sampled monitor clock. When the loop has converged, it keeps nudging its setting in one direction at a slow, regular rate. The detector treats two rising edges of the same correction direction, close enough together, as evidence of that steady state.

The first qualifying edge opens a window. The 2-bit unlock-program input selects the window length: 4, 8, 16 or 32 sample cycles for codes 2'b00, 2'b01, 2'b10 and 2'b11, with all four lengths set by parameters. A second edge of the same direction inside the window raises the lock flag. If the window runs out first, the evidence is discarded and the next edge starts afresh. Once raised, the lock flag holds until the block is disabled or the search-done flag drops.

Top module: `fllLockDetect`

## Requirements
- R1: While rstN is low, and on the first edge after it is released, lockFlag is 0.
- R2: When enable is 0 at a clock edge, lockFlag is 0 after that edge and all edge evidence is discarded.
- R3: Edges seen while searchDone is 0 are ignored. When searchDone is 0 at a clock edge, lockFlag is 0 after that edge.
- R4: Two rising edges of incPulse, d sample cycles apart with 1 <= d <= window length, raise lockFlag at the edge that samples the second rising edge.
- R5: Two rising edges of decPulse obey the same rule as R4.
- R6: The two edges need not be adjacent. Any number of idle cycles may separate them, provided the distance stays within the window.
- R7: A rising edge of incPulse and a rising edge of decPulse do not make a pair, so a mixed pair never raises lockFlag.
- R8: The window length is measured from the first edge and chosen by unlockProg: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 32 cycles. A second edge at exactly that distance locks. One cycle later it does not.
- R9: When the window expires without a pair, all evidence clears. Any later edge, including one at distance window+1, opens a new window.
- R10: Only rising edges count. A level held high counts once, and a signal already high when searchDone rises is not an edge.
- R11: Once raised, lockFlag stays 1 regardless of further correction edges while enable and searchDone both stay 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sampleClk | input | 1 | Sampled monitor clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detector enable; low clears and unlocks |
| searchDone | input | 1 | Coarse search end-of-conversion flag |
| incPulse | input | 1 | Increment correction signal, synchronous to sampleClk |
| decPulse | input | 1 | Decrement correction signal, synchronous to sampleClk |
| unlockProg | input | 2 | Window length select code |
| lockFlag | output | 1 | Registered lock indication |

## Verification
Corrupted internal state appears at lockFlag only when the next correction edge arrives. Examples are a per-direction count that fails to clear, a window timer off by one, or a stale previous-value register. The effect is a lock one edge too early or too late, or a lock from a mixed pair. For this reason the bench places second edges exactly at the window boundary and one cycle beyond it, for several codes. It also compares lockFlag every cycle against a behavioural model, so any divergence shows within one cycle of the edge that exposes it.

// File: rtl/fllLockPkg.sv
package fllLockPkg;

  typedef struct packed {
    logic clearAll;
    logic openWin;
    logic accumulate;
  } lockStrobe_t;

  function automatic logic [1:0] satBump(input logic [1:0] cnt, input logic hit);
    if (!hit || cnt == 2'b11) return cnt;
    return cnt + 2'd1;
  endfunction

endpackage

// File: rtl/fllLockDatapath.sv
module fllLockDatapath
  import fllLockPkg::*;
#(
  parameter int WIN_CODE0 = 4,
  parameter int WIN_CODE1 = 8,
  parameter int WIN_CODE2 = 16,
  parameter int WIN_CODE3 = 32
) (
  input  logic        sampleClk,
  input  logic        rstN,
  input  logic        incPulse,
  input  logic        decPulse,
  input  logic [1:0]  unlockProg,
  input  lockStrobe_t strobe,
  output logic        incRise,
  output logic        decRise,
  output logic [1:0]  incCnt,
  output logic [1:0]  decCnt,
  output logic        winOn,
  output logic        atLimit
);

  localparam int MAX_LO  = (WIN_CODE0 > WIN_CODE1) ? WIN_CODE0 : WIN_CODE1;
  localparam int MAX_HI  = (WIN_CODE2 > WIN_CODE3) ? WIN_CODE2 : WIN_CODE3;
  localparam int MAX_WIN = (MAX_LO > MAX_HI) ? MAX_LO : MAX_HI;
  localparam int TIMER_W = $clog2(MAX_WIN + 1);

  logic               incPrev;
  logic               decPrev;
  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] limitSel;

  assign incRise = incPulse & ~incPrev;
  assign decRise = decPulse & ~decPrev;

  always_comb begin
    unique case (unlockProg)
      2'b00:   limitSel = TIMER_W'(WIN_CODE0);
      2'b01:   limitSel = TIMER_W'(WIN_CODE1);
      2'b10:   limitSel = TIMER_W'(WIN_CODE2);
      default: limitSel = TIMER_W'(WIN_CODE3);
    endcase
  end

  assign atLimit = winOn && (timer >= limitSel);

  always_ff @(posedge sampleClk or negedge rstN) begin
    if (!rstN) begin
      incPrev <= 1'b0;
      decPrev <= 1'b0;
    end else begin
      incPrev <= incPulse;
      decPrev <= decPulse;
    end
  end

  always_ff @(posedge sampleClk or negedge rstN) begin
    if (!rstN) begin
      winOn  <= 1'b0;
      incCnt <= 2'd0;
      decCnt <= 2'd0;
      timer  <= '0;
    end else if (strobe.clearAll) begin
      winOn  <= 1'b0;
      incCnt <= 2'd0;
      decCnt <= 2'd0;
      timer  <= '0;
    end else if (strobe.openWin) begin
      winOn  <= 1'b1;
      incCnt <= {1'b0, incRise};
      decCnt <= {1'b0, decRise};
      timer  <= TIMER_W'(1);
    end else if (strobe.accumulate) begin
      incCnt <= satBump(incCnt, incRise);
      decCnt <= satBump(decCnt, decRise);
      timer  <= timer + TIMER_W'(1);
    end
  end

  assert_idle_clear_R9: assert property (@(posedge sampleClk) disable iff (!rstN)
    !winOn |-> (incCnt == 2'd0 && decCnt == 2'd0 && timer == '0));

  assert_single_edge_pending_R7: assert property (@(posedge sampleClk) disable iff (!rstN)
    winOn |-> (incCnt < 2'd2 && decCnt < 2'd2 && timer != '0));

endmodule

// File: rtl/fllLockCtrl.sv
module fllLockCtrl
  import fllLockPkg::*;
(
  input  logic        sampleClk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        searchDone,
  input  logic        incRise,
  input  logic        decRise,
  input  logic [1:0]  incCnt,
  input  logic [1:0]  decCnt,
  input  logic        winOn,
  input  logic        atLimit,
  output lockStrobe_t strobe,
  output logic        lockFlag
);

  logic active;
  logic anyRise;
  logic pairHit;
  logic lockNext;

  assign active  = enable & searchDone;
  assign anyRise = incRise | decRise;
  assign pairHit = (incRise && incCnt == 2'd1) || (decRise && decCnt == 2'd1);

  always_comb begin
    strobe   = '0;
    lockNext = lockFlag;
    if (!active) begin
      strobe.clearAll = 1'b1;
      lockNext        = 1'b0;
    end else if (lockFlag) begin
      strobe.clearAll = 1'b1;
    end else if (!winOn) begin
      strobe.openWin = anyRise;
    end else if (pairHit) begin
      strobe.clearAll = 1'b1;
      lockNext        = 1'b1;
    end else if (atLimit) begin
      strobe.openWin  = anyRise;
      strobe.clearAll = ~anyRise;
    end else begin
      strobe.accumulate = 1'b1;
    end
  end

  always_ff @(posedge sampleClk or negedge rstN) begin
    if (!rstN) lockFlag <= 1'b0;
    else       lockFlag <= lockNext;
  end

  assert_inactive_unlock_R2: assert property (@(posedge sampleClk) disable iff (!rstN)
    !(enable && searchDone) |=> !lockFlag);

  assert_lock_hold_R11: assert property (@(posedge sampleClk) disable iff (!rstN)
    (lockFlag && enable && searchDone) |=> lockFlag);

  assert_lock_cause_R4: assert property (@(posedge sampleClk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(winOn && ((incRise && incCnt == 2'd1) || (decRise && decCnt == 2'd1))));

  assert_strobe_exclusive_R9: assert property (@(posedge sampleClk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/fllLockDetect.sv
module fllLockDetect
  import fllLockPkg::*;
#(
  parameter int WIN_CODE0 = 4,
  parameter int WIN_CODE1 = 8,
  parameter int WIN_CODE2 = 16,
  parameter int WIN_CODE3 = 32
) (
  input  logic       sampleClk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       searchDone,
  input  logic       incPulse,
  input  logic       decPulse,
  input  logic [1:0] unlockProg,
  output logic       lockFlag
);

  lockStrobe_t strobe;
  logic        incRise;
  logic        decRise;
  logic [1:0]  incCnt;
  logic [1:0]  decCnt;
  logic        winOn;
  logic        atLimit;

  fllLockDatapath #(
    .WIN_CODE0(WIN_CODE0),
    .WIN_CODE1(WIN_CODE1),
    .WIN_CODE2(WIN_CODE2),
    .WIN_CODE3(WIN_CODE3)
  ) dpath_i (
    .sampleClk (sampleClk),
    .rstN      (rstN),
    .incPulse  (incPulse),
    .decPulse  (decPulse),
    .unlockProg(unlockProg),
    .strobe    (strobe),
    .incRise   (incRise),
    .decRise   (decRise),
    .incCnt    (incCnt),
    .decCnt    (decCnt),
    .winOn     (winOn),
    .atLimit   (atLimit)
  );

  fllLockCtrl ctrl_i (
    .sampleClk (sampleClk),
    .rstN      (rstN),
    .enable    (enable),
    .searchDone(searchDone),
    .incRise   (incRise),
    .decRise   (decRise),
    .incCnt    (incCnt),
    .decCnt    (decCnt),
    .winOn     (winOn),
    .atLimit   (atLimit),
    .strobe    (strobe),
    .lockFlag  (lockFlag)
  );

  assert_reset_low_R1: assert property (@(posedge sampleClk)
    !rstN |-> !lockFlag);

endmodule

// File: tb/fllLockDetect_tb_top.sv
`timescale 1ns/1ps
module fllLockDetect_tb_top;

  logic       sampleClk = 1'b0;
  logic       rstN;
  logic       enable;
  logic       searchDone;
  logic       incPulse;
  logic       decPulse;
  logic [1:0] unlockProg;
  logic       lockFlag;

  int errors = 0;
  int checks = 0;
  string curTag = "R1";

  int mPrevInc = 0, mPrevDec = 0, mOpen = 0, mDist = 0;
  int mInc = 0, mDec = 0, mLock = 0;

  always #2.5 sampleClk = ~sampleClk;

  fllLockDetect dut_i (
    .sampleClk (sampleClk),
    .rstN      (rstN),
    .enable    (enable),
    .searchDone(searchDone),
    .incPulse  (incPulse),
    .decPulse  (decPulse),
    .unlockProg(unlockProg),
    .lockFlag  (lockFlag)
  );

  function automatic int winLen(input logic [1:0] code);
    case (code)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 16;
      default: return 32;
    endcase
  endfunction

  task automatic modelStep();
    int ri, rd;
    ri = (incPulse && !mPrevInc) ? 1 : 0;
    rd = (decPulse && !mPrevDec) ? 1 : 0;
    mPrevInc = incPulse;
    mPrevDec = decPulse;
    if (!(enable && searchDone)) begin
      mLock = 0; mOpen = 0;
    end else if (mLock) begin
      mOpen = 0;
    end else if (!mOpen) begin
      if (ri || rd) begin mOpen = 1; mDist = 0; mInc = ri; mDec = rd; end
    end else begin
      mDist++;
      if ((ri && mInc == 1) || (rd && mDec == 1)) begin
        mLock = 1; mOpen = 0;
      end else if (mDist >= winLen(unlockProg)) begin
        mOpen = 0;
        if (ri || rd) begin mOpen = 1; mDist = 0; mInc = ri; mDec = rd; end
      end else begin
        mInc += ri; mDec += rd;
      end
    end
  endtask

  task automatic check(input logic expV, input string tag);
    checks++;
    if (lockFlag !== expV) begin
      errors++;
      $display("FAIL %s: lockFlag=%0b expected=%0b at %0t", tag, lockFlag, expV, $time);
    end
  endtask

  task automatic cyc();
    @(posedge sampleClk);
    modelStep();
    @(negedge sampleClk);
    check(mLock[0], curTag);
  endtask

  task automatic idle();
    incPulse = 0; decPulse = 0; searchDone = 0;
    cyc();
    searchDone = 1;
    cyc();
  endtask

  task automatic pairGap(input bit useInc, input int d);
    if (useInc) incPulse = 1; else decPulse = 1;
    cyc();
    incPulse = 0; decPulse = 0;
    for (int i = 0; i < d - 1; i++) cyc();
    if (useInc) incPulse = 1; else decPulse = 1;
    cyc();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    rstN = 0; enable = 0; searchDone = 0; incPulse = 0; decPulse = 0; unlockProg = 2'b01;
    #1;
    curTag = "R1";
    check(1'b0, "R1 during reset");
    @(negedge sampleClk); @(negedge sampleClk);
    rstN = 1;
    enable = 1; searchDone = 1;
    cyc();
    check(1'b0, "R1 after release");

    curTag = "R4";
    idle();
    pairGap(1, 4);
    check(1'b1, "R4 inc pair");
    curTag = "R11";
    incPulse = 0;
    for (int i = 0; i < 6; i++) begin decPulse = i[0]; incPulse = ~i[0]; cyc(); end
    check(1'b1, "R11 hold under edges");
    curTag = "R3";
    searchDone = 0; incPulse = 0; decPulse = 0;
    cyc();
    check(1'b0, "R3 unlock on search drop");
    pairGap(1, 2);
    check(1'b0, "R3 edges ignored while not done");

    curTag = "R5";
    idle();
    pairGap(0, 8);
    check(1'b1, "R5 dec pair at window edge");

    curTag = "R6";
    idle();
    pairGap(0, 6);
    check(1'b1, "R6 non-adjacent pair");

    curTag = "R8";
    idle();
    pairGap(1, 9);
    check(1'b0, "R8 code01 distance 9");
    curTag = "R9";
    incPulse = 0; cyc(); cyc();
    incPulse = 1; cyc();
    check(1'b1, "R9 edge past window starts new one");

    curTag = "R7";
    idle();
    incPulse = 1; cyc(); incPulse = 0; cyc(); cyc();
    decPulse = 1; cyc(); decPulse = 0; cyc();
    check(1'b0, "R7 mixed pair");

    curTag = "R8";
    unlockProg = 2'b00;
    idle(); pairGap(1, 4); check(1'b1, "R8 code00 distance 4");
    idle(); pairGap(1, 5); check(1'b0, "R8 code00 distance 5");
    unlockProg = 2'b10;
    idle(); pairGap(0, 16); check(1'b1, "R8 code10 distance 16");
    idle(); pairGap(0, 17); check(1'b0, "R8 code10 distance 17");
    unlockProg = 2'b11;
    idle(); pairGap(1, 32); check(1'b1, "R8 code11 distance 32");
    idle(); pairGap(1, 33); check(1'b0, "R8 code11 distance 33");
    unlockProg = 2'b01;

    curTag = "R2";
    idle(); pairGap(0, 3);
    enable = 0; decPulse = 0; cyc();
    check(1'b0, "R2 disable unlocks");
    decPulse = 1; cyc(); decPulse = 0; cyc();
    enable = 1; cyc();
    decPulse = 1; cyc(); decPulse = 0; cyc();
    check(1'b0, "R2 evidence cleared while disabled");

    curTag = "R10";
    idle();
    incPulse = 1;
    for (int i = 0; i < 12; i++) cyc();
    check(1'b0, "R10 held level counts once");
    incPulse = 0; searchDone = 0; cyc();
    incPulse = 1; cyc();
    searchDone = 1; cyc(); cyc();
    incPulse = 0; cyc(); incPulse = 1; cyc();
    check(1'b0, "R10 high at search start not an edge");

    curTag = "random";
    for (int i = 0; i < 4000; i++) begin
      enable     = ($urandom_range(0, 99) != 0);
      searchDone = ($urandom_range(0, 49) != 0);
      incPulse   = ($urandom_range(0, 9) < 2);
      decPulse   = ($urandom_range(0, 9) < 2);
      if ($urandom_range(0, 29) == 0) unlockProg = 2'($urandom_range(0, 3));
      cyc();
    end

    finishRun();
  end

endmodule